// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM. It takes the memory from power-on to a state where it is ready for use. It is a fixed-order state machine. First it holds the clock enable and the byte masks high and issues only no-operation commands for a long settling pause. It then precharges every bank and issues a parameterised number of auto-refresh commands. It also writes the mode register. The refresh step and the mode-register step can run in either order. Every wait is counted in clock cycles, and the pause length is derived from the clock frequency parameter.

The mode register value is assembled from four parameters: burst length code, burst type, CAS latency and write burst mode. When the sequence is finished, `init_done` rises and the command bus stays at no-operation. A memory controller holds off its normal traffic until then. Refresh scheduling, reads, writes and the data path are not part of this block.

Top module: `sdram_bringup_seq`

## Requirements
- R1: From reset until `init_done`, `cke` is 1 and every bit of `dqm` is 1.
- R2: The first CLK_MHZ×PAUSE_US cycles after reset carry the no-operation command {cs_n,ras_n,cas_n,we_n}=0111, with `addr` and `ba` at zero.
- R3: The cycle right after the pause carries precharge-all: command 0010, `addr[10]`=1, all other address bits zero, `ba`=0.
- R4: The precharge is followed by TRP_CYC no-operation cycles. Then come REFRESH_COUNT auto-refresh commands (command 0001, address zero), each followed by TRFC_CYC no-operation cycles. A REFRESH_COUNT below 2 is raised to 2.
- R5: The mode register write is command 0000 with `ba`=0. It places the burst length code on `addr[2:0]`, the burst type on `addr[3]`, the CAS latency on `addr[6:4]` and the write burst mode on `addr[9]`. `addr[8:7]`, `addr[10]` and `addr[11]` are 0.
- R6: With MODE_FIRST=1, the mode register write comes directly after the precharge gap. It is followed by TMRD_CYC no-operation cycles, and then by the refresh step.
- R7: In the default order, `init_done` rises in the cycle after the mode register write. With MODE_FIRST=1, it rises in the cycle after the last refresh gap. Once high, it stays high, and the bus holds no-operation.
- R8: A synchronous active-high `rst` clears `init_done` and restarts the pause from its first cycle, from any point in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Byte masks to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus; carries A10 for precharge-all and the mode word |
| init_done | output | 1 | High once the bring-up sequence has completed |

## Verification
The hardest state to reach from the ports is a reset that arrives deep inside the sequence. Reaching the refresh step takes tens of thousands of pause cycles, so the bench first runs the whole sequence. It then resets from the finished state, runs again past the precharge into the first refresh gap, and resets there. A second instance is built with the swapped order, a shorter pause and three refreshes, so that both orderings and a non-minimum refresh count are observed under the same resets. Both are compared on every cycle against a queue of expected bus words.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_GAP_RP,
    ST_REF,
    ST_GAP_RFC,
    ST_MRS,
    ST_GAP_MRD,
    ST_DONE
  } step_t;

  // number of settling cycles for a pause of us microseconds at mhz
  function automatic int unsigned pause_cycles(int unsigned mhz, int unsigned us);
    int unsigned n;
    n = mhz * us;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned at_least(int unsigned v, int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // mode register word as placed on the address pins
  function automatic logic [11:0] mode_word(logic [2:0] burst_code, logic burst_ilv,
                                            logic [2:0] cas_lat, logic wr_single);
    logic [11:0] w;
    w       = '0;
    w[2:0]  = burst_code;
    w[3]    = burst_ilv;
    w[6:4]  = cas_lat;
    w[9]    = wr_single;
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
`timescale 1ns/1ps
module sdram_init_timer #(
  parameter int unsigned CW      = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CW'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // the down-counter rests at zero instead of wrapping
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);

  // a load of a non-zero value always yields at least one waiting cycle
  assert_load_waits_R4: assert property (@(posedge clk) disable iff (rst)
    (load && (load_val != '0)) |=> !expired);

endmodule

// File: rtl/sdram_init_fsm.sv
`timescale 1ns/1ps
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned REF_N      = 2,
  parameter bit          MODE_FIRST = 1'b0,
  parameter int unsigned CW         = 16,
  parameter int unsigned RP_LOAD    = 0,
  parameter int unsigned RFC_LOAD   = 0,
  parameter int unsigned MRD_LOAD   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expired,
  output step_t         step,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          pre_fire,
  output logic          ref_fire,
  output logic          mrs_fire,
  output logic          done
);

  localparam int unsigned RW = $clog2(REF_N + 1);

  step_t         nxt;
  logic [RW-1:0] ref_cnt;
  logic          refs_complete;

  assign refs_complete = (ref_cnt == RW'(REF_N));

  always_comb begin
    nxt      = step;
    load     = 1'b0;
    load_val = '0;
    unique case (step)
      ST_PAUSE:   if (expired) nxt = ST_PRE;
      ST_PRE: begin
        nxt      = ST_GAP_RP;
        load     = 1'b1;
        load_val = CW'(RP_LOAD);
      end
      ST_GAP_RP:  if (expired) nxt = MODE_FIRST ? ST_MRS : ST_REF;
      ST_REF: begin
        nxt      = ST_GAP_RFC;
        load     = 1'b1;
        load_val = CW'(RFC_LOAD);
      end
      ST_GAP_RFC: begin
        if (expired) begin
          if (!refs_complete) nxt = ST_REF;
          else                nxt = MODE_FIRST ? ST_DONE : ST_MRS;
        end
      end
      ST_MRS: begin
        if (MODE_FIRST) begin
          nxt      = ST_GAP_MRD;
          load     = 1'b1;
          load_val = CW'(MRD_LOAD);
        end else begin
          nxt = ST_DONE;
        end
      end
      ST_GAP_MRD: if (expired) nxt = ST_REF;
      ST_DONE:    nxt = ST_DONE;
      default:    nxt = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= ST_PAUSE;
      ref_cnt <= '0;
    end else begin
      step <= nxt;
      if (step == ST_REF) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  assign pre_fire = (step == ST_PRE);
  assign ref_fire = (step == ST_REF);
  assign mrs_fire = (step == ST_MRS);
  assign done     = (step == ST_DONE);

  // at most one real command per cycle
  assert_one_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pre_fire, ref_fire, mrs_fire}));

  // completion only after the full refresh count
  assert_ref_total_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (ref_cnt == RW'(REF_N)));

  // completion is sticky until reset
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  generate
    if (MODE_FIRST) begin : g_swap
      // mode write never ends the sequence in swapped order
      assert_mrs_then_gap_R6: assert property (@(posedge clk) disable iff (rst)
        mrs_fire |=> !done);
    end else begin : g_plain
      assert_done_after_mrs_R7: assert property (@(posedge clk) disable iff (rst)
        mrs_fire |=> done);
    end
  endgenerate

endmodule

// File: rtl/sdram_cmd_drive.sv
`timescale 1ns/1ps
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter logic [11:0] MODE_VAL = 12'h000,
  parameter int unsigned DQM_W    = 2
) (
  input  step_t             step,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [11:0]       addr,
  output logic              cmd_nop
);

  localparam int unsigned ALL_BANKS_BIT = 10;

  cmd_t cmd;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    unique case (step)
      ST_PRE: begin
        cmd                 = CMD_PRE;
        addr[ALL_BANKS_BIT] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin
        cmd  = CMD_MRS;
        addr = MODE_VAL;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba      = 2'b00;
  assign cke     = 1'b1;
  assign dqm     = '1;
  assign cmd_nop = (cmd == CMD_NOP);

endmodule

// File: rtl/sdram_bringup_seq.sv
`timescale 1ns/1ps
module sdram_bringup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ          = 200,
  parameter int unsigned PAUSE_US         = 200,
  parameter int unsigned REFRESH_COUNT    = 2,
  parameter logic [2:0]  BURST_CODE       = 3'd3,
  parameter bit          BURST_INTERLEAVE = 1'b0,
  parameter logic [2:0]  CAS_LAT          = 3'd3,
  parameter bit          WRITE_SINGLE     = 1'b0,
  parameter bit          MODE_FIRST       = 1'b0,
  parameter int unsigned TRP_CYC          = 4,
  parameter int unsigned TRFC_CYC         = 14,
  parameter int unsigned TMRD_CYC         = 2,
  parameter int unsigned DQM_W            = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             cke,
  output logic [DQM_W-1:0] dqm,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [1:0]       ba,
  output logic [11:0]      addr,
  output logic             init_done
);

  localparam int unsigned PAUSE_N  = pause_cycles(CLK_MHZ, PAUSE_US);
  localparam int unsigned REF_N    = at_least(REFRESH_COUNT, 2);
  localparam int unsigned RP_N     = at_least(TRP_CYC, 1);
  localparam int unsigned RFC_N    = at_least(TRFC_CYC, 1);
  localparam int unsigned MRD_N    = at_least(TMRD_CYC, 1);
  localparam int unsigned LONGEST  = max_of4(PAUSE_N, RP_N, RFC_N, MRD_N);
  localparam int unsigned CW       = $clog2(LONGEST + 1);
  localparam logic [11:0] MODE_VAL = mode_word(BURST_CODE, BURST_INTERLEAVE,
                                               CAS_LAT, WRITE_SINGLE);

  step_t         step;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;
  logic          pre_fire;
  logic          ref_fire;
  logic          mrs_fire;
  logic          done;
  logic          cmd_nop;

  sdram_init_timer #(
    .CW      (CW),
    .RST_VAL (PAUSE_N - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sdram_init_fsm #(
    .REF_N      (REF_N),
    .MODE_FIRST (MODE_FIRST),
    .CW         (CW),
    .RP_LOAD    (RP_N - 1),
    .RFC_LOAD   (RFC_N - 1),
    .MRD_LOAD   (MRD_N - 1)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .expired  (expired),
    .step     (step),
    .load     (load),
    .load_val (load_val),
    .pre_fire (pre_fire),
    .ref_fire (ref_fire),
    .mrs_fire (mrs_fire),
    .done     (done)
  );

  sdram_cmd_drive #(
    .MODE_VAL (MODE_VAL),
    .DQM_W    (DQM_W)
  ) u_drive (
    .step    (step),
    .cke     (cke),
    .dqm     (dqm),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr),
    .cmd_nop (cmd_nop)
  );

  assign init_done = done;

  // the cycle after precharge or refresh is a no-operation gap cycle
  assert_pre_gap_R4: assert property (@(posedge clk) disable iff (rst)
    pre_fire |=> cmd_nop);
  assert_ref_gap_R4: assert property (@(posedge clk) disable iff (rst)
    ref_fire |=> cmd_nop);

  // finished sequencer keeps the bus quiet
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd_nop && !cs_n));

  // the pause begins with a no-operation right after reset
  assert_pause_start_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cmd_nop && !init_done));

endmodule

// File: tb/sdram_bringup_seq_tb.sv
`timescale 1ns/1ps
module sdram_bringup_seq_tb;

  localparam logic [17:0] NOP_W = {4'b0111, 2'b00, 12'h000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // instance A: default parameters
  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_dqm, a_ba;
  logic [11:0] a_addr;
  // instance B: swapped order, 50 MHz pause, three refreshes
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_dqm, b_ba;
  logic [11:0] b_addr;

  sdram_bringup_seq u_dut (
    .clk(clk), .rst(rst), .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs), .ras_n(a_ras),
    .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done));

  sdram_bringup_seq #(
    .CLK_MHZ(50), .REFRESH_COUNT(3), .BURST_CODE(3'd1), .BURST_INTERLEAVE(1'b1),
    .CAS_LAT(3'd2), .WRITE_SINGLE(1'b1), .MODE_FIRST(1'b1), .TRP_CYC(3),
    .TRFC_CYC(9), .TMRD_CYC(2)
  ) u_dut_swap (
    .clk(clk), .rst(rst), .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs), .ras_n(b_ras),
    .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done));

  int total = 0;
  int bad   = 0;
  bit started  = 0;
  bit finished = 0;
  int since    = 0;

  logic [17:0] qa[$];
  logic [17:0] qb[$];
  string       ta[$];
  string       tb_q[$];

  // mode word built as a sum of shifted fields
  function automatic logic [11:0] mword(int bl, int bt, int cl, int wb);
    return 12'(bl + (bt * 8) + (cl * 16) + (wb * 512));
  endfunction

  task automatic build(ref logic [17:0] q[$], ref string t[$], input int pause,
                       input int nref, input int trp, input int trfc, input int tmrd,
                       input bit mode_first, input logic [11:0] mw);
    q.delete(); t.delete();
    for (int i = 0; i < pause; i++) begin q.push_back(NOP_W); t.push_back("R2"); end
    q.push_back({4'b0010, 2'b00, 12'h400}); t.push_back("R3");
    for (int i = 0; i < trp; i++) begin q.push_back(NOP_W); t.push_back("R4"); end
    if (mode_first) begin
      q.push_back({4'b0000, 2'b00, mw}); t.push_back("R6");
      for (int i = 0; i < tmrd; i++) begin q.push_back(NOP_W); t.push_back("R6"); end
    end
    for (int r = 0; r < nref; r++) begin
      q.push_back({4'b0001, 2'b00, 12'h000}); t.push_back("R4");
      for (int i = 0; i < trfc; i++) begin q.push_back(NOP_W); t.push_back("R4"); end
    end
    if (!mode_first) begin q.push_back({4'b0000, 2'b00, mw}); t.push_back("R5"); end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // reference model steps on the rising edge
  always @(posedge clk) begin
    if (rst) begin
      build(qa, ta, 40000, 2, 4, 14, 2, 1'b0, mword(3, 0, 3, 0));
      build(qb, tb_q, 10000, 3, 3, 9, 2, 1'b1, mword(1, 1, 2, 1));
      since   = 0;
      started = 1;
    end else begin
      since++;
      if (qa.size() > 0) begin qa.delete(0); ta.delete(0); end
      if (qb.size() > 0) begin qb.delete(0); tb_q.delete(0); end
    end
  end

  // compare on the falling edge
  always @(negedge clk) begin
    if (started && !finished && !rst) begin
      logic [17:0] ea, eb, ga, gb;
      string sa, sb;
      bit da, db;
      ea = (qa.size() > 0) ? qa[0] : NOP_W;
      eb = (qb.size() > 0) ? qb[0] : NOP_W;
      da = (qa.size() == 0);
      db = (qb.size() == 0);
      sa = (since == 0) ? "R8" : ((qa.size() > 0) ? ta[0] : "R7");
      sb = (since == 0) ? "R8" : ((qb.size() > 0) ? tb_q[0] : "R7");
      ga = {a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
      gb = {b_cs, b_ras, b_cas, b_we, b_ba, b_addr};
      chk(ga === ea, sa, "bus A", 32'(ga), 32'(ea));
      chk(gb === eb, sb, "bus B", 32'(gb), 32'(eb));
      chk(a_done === da, sa, "init_done A", 32'(a_done), 32'(da));
      chk(b_done === db, sb, "init_done B", 32'(b_done), 32'(db));
      // R1: clock enable and masks held high
      chk({a_cke, a_dqm, b_cke, b_dqm} === 6'h3F, "R1", "cke/dqm",
          32'({a_cke, a_dqm, b_cke, b_dqm}), 32'h3F);
    end
  end

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // run A: both instances complete
    repeat (40200) @(posedge clk);
    @(negedge clk);
    chk(a_done === 1'b1 && b_done === 1'b1, "R7", "both done",
        32'({a_done, b_done}), 32'h3);
    // R8: reset from the finished state
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    // run B: stop inside the first refresh gap of instance A
    repeat (40008) @(posedge clk);
    @(negedge clk);
    chk(a_done === 1'b0, "R8", "mid-run A not done", 32'(a_done), 32'h0);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    // run C: full sequence again after the mid-run reset
    repeat (40200) @(posedge clk);
    @(negedge clk);
    chk(a_done === 1'b1 && b_done === 1'b1, "R8", "done after restart",
        32'({a_done, b_done}), 32'h3);
    summary();
  end

endmodule